// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Controller

This block is the device-side control logic for a one-time-programmable program store while the store is in programming mode. It samples three active-low strobes (chip enable `ce_n`, output enable `oe_n`, program `pgm_n`) on every clock and decodes them into one of eight named modes. The mode then decides three things: whether the byte bus is driven, whether write data is gathered into a four-entry page buffer, and whether a program pulse commits one byte or a whole page into the cell array.

Programming mode exists only while the device reset pin `sel_rst_n` is held low and the supply qualifier `vpp_ok` is high. The high programming voltage is reduced to that single qualifier. The bus is split into `data_in`, `data_out` and an enable `data_oe`, which the pad ring turns into a three-state pin.

The cell array is behavioural and is built as four byte lanes, one for each low address value. A page commit therefore writes all four lanes in a single cycle. Programming can only clear bits, and an erased cell reads 0xFF.

The eight modes, with (`ce_n`,`oe_n`,`pgm_n`) written as H or L:

| Mode | Strobes (`ce_n`,`oe_n`,`pgm_n`) | Effect |
|------|---------------------------------|--------|
| `M_OFF` | any | Not in programming mode |
| `M_STANDBY` | H,H,H or H,L,L | Idle, bus released |
| `M_OUTDIS` | L,H,H | Bus released |
| `M_LATCH` | H,L,H | Byte captured into the page buffer |
| `M_PAGE_PGM` | H,H,L | Page program |
| `M_BYTE_PGM` | L,H,L | Byte program |
| `M_VERIFY` | L,L,H | Addressed byte driven onto the bus |
| `M_INHIBIT` | L,L,L | No drive, no write |

Every clock, the mode register loads the decoded mode. The decode is the same from every state, so any mode can follow any other. The one edge that matters is the entry into `M_PAGE_PGM` or `M_BYTE_PGM` from any other mode: that entry is the commit event.

Top module: `otp_prog_ctrl`

## Requirements
- R1: Programming mode is active only while `sel_rst_n`=0 and `vpp_ok`=1. Outside it, `data_oe` is 0 one cycle later and program pulses change no cell.
- R2: With `ce_n`=1 and `oe_n`=`pgm_n` (both high or both low), the block is in standby. `data_oe` is 0 on the next cycle and no cell changes.
- R3: With `ce_n`=0, `oe_n`=1 and `pgm_n`=1, the bus is released (`data_oe`=0 on the next cycle).
- R4: With `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `data_oe` is 1 one clock later and `data_out` carries the byte stored at `addr`.
- R5: With `ce_n`=1, `oe_n`=0 and `pgm_n`=1, each clock stores `data_in` into page-buffer entry `addr[1:0]`, and `data_oe` stays 0.
- R6: With `ce_n`=1 and `oe_n`=1, a low pulse on `pgm_n` programs the four buffered bytes into the page selected by `addr[ADDR_W-1:2]`. Entry k goes to the byte whose `addr[1:0]`=k. The buffer then returns to 0xFF in every entry.
- R7: With `ce_n`=0 and `oe_n`=1, a low pulse on `pgm_n` programs `data_in` into the single byte at `addr`.
- R8: After reset every cell reads 0xFF, and a program operation stores the bitwise AND of the old byte and the new byte. A commit happens once per pulse however long `pgm_n` stays low.
- R9: With all three strobes low, the bus is released and no cell changes.
- R10: Address bits at and above `STORE_AW` are ignored, so addresses that differ only there reach the same cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| sel_rst_n | input | 1 | Device reset pin; low is one condition for programming mode |
| vpp_ok | input | 1 | Programming supply present qualifier |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| addr | input | ADDR_W (17) | Byte address |
| data_in | input | DATA_W (8) | Write / latch data from the bus |
| data_out | output | DATA_W (8) | Read data toward the bus |
| data_oe | output | 1 | Registered bus drive enable |

## Verification
The bench builds the block with `STORE_AW`=6, which gives a 64-byte array of sixteen pages, while the address bus stays 17 bits wide. This small array lets the bench read back every cell after each phase. It also lets it byte-program every address, program every page through the page buffer, and program each cell twice to show that bits only clear. Addresses with high bits set then show the aliasing rule. Every strobe combination, together with the two conditions that block programming mode, is tried against a reference array kept in the bench.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        M_OFF,
        M_STANDBY,
        M_OUTDIS,
        M_LATCH,
        M_PAGE_PGM,
        M_BYTE_PGM,
        M_VERIFY,
        M_INHIBIT
    } otp_mode_e;

    localparam int unsigned PAGE_BYTES = 4;
    localparam int unsigned PAGE_SEL_W = 2;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      sel_rst_n,
    input  logic      vpp_ok,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    output otp_mode_e mode
);

    always_comb begin
        mode = M_OFF;
        if (!sel_rst_n && vpp_ok) begin
            unique case ({ce_n, oe_n, pgm_n})
                3'b111:  mode = M_STANDBY;
                3'b100:  mode = M_STANDBY;
                3'b101:  mode = M_LATCH;
                3'b110:  mode = M_PAGE_PGM;
                3'b011:  mode = M_OUTDIS;
                3'b010:  mode = M_BYTE_PGM;
                3'b001:  mode = M_VERIFY;
                3'b000:  mode = M_INHIBIT;
                default: mode = M_OFF;
            endcase
        end
    end

endmodule

// File: rtl/otp_page_buf.sv
module otp_page_buf
    import otp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap,
    input  logic [PAGE_SEL_W-1:0] sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  clr,
    output logic [DATA_W-1:0]     ent [PAGE_BYTES]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PAGE_BYTES; k++) ent[k] <= '1;
        end else if (cap) begin
            ent[sel] <= wdata;
        end else if (clr) begin
            for (int k = 0; k < PAGE_BYTES; k++) ent[k] <= '1;
        end
    end

endmodule

// File: rtl/otp_lane.sv
module otp_lane #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) cells[k] <= '1;
        end else if (we) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_rst_n,
    input  logic              vpp_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    localparam int unsigned IDX_W = STORE_AW - PAGE_SEL_W;

    otp_mode_e mode_d;
    otp_mode_e mode_q;

    logic                  pg_wr;
    logic                  by_wr;
    logic                  buf_cap;
    logic [PAGE_SEL_W-1:0] lane_sel;
    logic [IDX_W-1:0]      row;
    logic [PAGE_BYTES-1:0] lane_we;
    logic [DATA_W-1:0]     buf_ent [PAGE_BYTES];
    logic [DATA_W-1:0]     lane_rd [PAGE_BYTES];

    assign lane_sel = addr[PAGE_SEL_W-1:0];
    assign row      = addr[STORE_AW-1:PAGE_SEL_W];

    otp_mode_decode u_dec (
        .sel_rst_n (sel_rst_n),
        .vpp_ok    (vpp_ok),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .pgm_n     (pgm_n),
        .mode      (mode_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_OFF;
        else        mode_q <= mode_d;
    end

    // mode-driven strobes
    always_comb begin
        pg_wr   = 1'b0;
        by_wr   = 1'b0;
        buf_cap = 1'b0;
        unique case (mode_d)
            M_PAGE_PGM: pg_wr   = (mode_q != M_PAGE_PGM);
            M_BYTE_PGM: by_wr   = (mode_q != M_BYTE_PGM);
            M_LATCH:    buf_cap = 1'b1;
            default:    ;
        endcase
    end

    otp_page_buf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (buf_cap),
        .sel   (lane_sel),
        .wdata (data_in),
        .clr   (pg_wr),
        .ent   (buf_ent)
    );

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign lane_we[g] = pg_wr || (by_wr && (lane_sel == PAGE_SEL_W'(g)));
        otp_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[g]),
            .idx   (row),
            .wdata (pg_wr ? buf_ent[g] : data_in),
            .rdata (lane_rd[g])
        );
    end

    // registered bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end else if (mode_d == M_VERIFY) begin
            data_oe  <= 1'b1;
            data_out <= lane_rd[lane_sel];
        end else begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end
    end

endmodule

// File: rtl/otp_prog_chk.sv
module otp_prog_chk
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_rst_n,
    input logic              vpp_ok,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic [ADDR_W-1:0] addr,
    input logic              data_oe,
    input logic [3:0]        lane_we
);

    // R1
    not_in_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rst_n || !vpp_ok) |=> !data_oe);

    // R1
    not_in_mode_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rst_n || !vpp_ok) |-> (lane_we == 4'b0000));

    // R2
    standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && (oe_n == pgm_n)) |=> !data_oe);

    // R3
    out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && pgm_n) |=> !data_oe);

    // R4
    verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rst_n && vpp_ok && !ce_n && !oe_n && pgm_n) |=> data_oe);

    // R5
    latch_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !oe_n && pgm_n) |=> !data_oe);

    // R7
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |-> $onehot0(lane_we));

    // R7
    byte_lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && (lane_we != 4'b0000)) |-> lane_we[addr[1:0]]);

    // R8
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_n && $past(!pgm_n) && $stable(ce_n) && $stable(oe_n)
         && $stable(sel_rst_n) && $stable(vpp_ok)) |-> (lane_we == 4'b0000));

    // R9
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !pgm_n) |-> ((lane_we == 4'b0000) ##1 !data_oe));

    // R10
    addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(addr) || sel_rst_n || !vpp_ok);

endmodule

bind otp_prog_ctrl otp_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_rst_n (sel_rst_n),
    .vpp_ok    (vpp_ok),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .pgm_n     (pgm_n),
    .addr      (addr),
    .data_oe   (data_oe),
    .lane_we   (lane_we)
);

// File: tb/sim_otp_prog_ctrl.sv
module sim_otp_prog_ctrl;

    localparam int unsigned AW = 17;
    localparam int unsigned SAW = 6;
    localparam int unsigned NB = 1 << SAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_rst_n = 1'b0;
    logic vpp_ok = 1'b1;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic pgm_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic data_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [NB];

    always #4 clk = ~clk;

    otp_prog_ctrl #(.ADDR_W(AW), .DATA_W(8), .STORE_AW(SAW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_rst_n(sel_rst_n), .vpp_ok(vpp_ok),
        .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic o, input logic p);
        ce_n = c; oe_n = o; pgm_n = p;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        pins(1'b0, 1'b0, 1'b1);
        addr = a;
        step();
        chk(data_oe === 1'b1, req, int'(data_oe), 1);
        chk(data_out === model[a % NB], req, int'(data_out), int'(model[a % NB]));
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NB; i++) read_chk(AW'(i), req);
    endtask

    task automatic byte_pulse(input logic [AW-1:0] a, input logic [7:0] d, input int hold);
        pins(1'b0, 1'b1, 1'b1);
        addr = a;
        data_in = d;
        step();
        pgm_n = 1'b0;
        for (int k = 0; k < hold; k++) step();
        pgm_n = 1'b1;
        step();
    endtask

    task automatic latch_byte(input logic [AW-1:0] a, input logic [7:0] d);
        pins(1'b1, 1'b0, 1'b1);
        addr = a;
        data_in = d;
        step();
        chk(data_oe === 1'b0, "R5 no drive while latching", int'(data_oe), 0);
    endtask

    task automatic page_pulse(input logic [AW-1:0] a);
        pins(1'b1, 1'b1, 1'b1);
        addr = a;
        data_in = 8'h00;
        step();
        pgm_n = 1'b0;
        step();
        step();
        pgm_n = 1'b1;
        step();
    endtask

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 37 + s * 11 + 5) ^ (s * 8'h5A));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;

        // reset state
        repeat (3) step();
        chk(data_oe === 1'b0, "R2 reset data_oe", int'(data_oe), 0);
        rst_n = 1'b1;
        step();

        // R8 erased contents, R4 verify of every cell
        read_all("R8 erased read");

        // R7 byte program of every cell
        for (int i = 0; i < NB; i++) begin
            d = pat(i, 1);
            byte_pulse(AW'(i), d, 1);
            model[i] = model[i] & d;
        end
        read_all("R7 byte program");

        // R8 second pass clears bits only; long pulse commits once
        for (int i = 0; i < NB; i++) begin
            d = pat(i, 2);
            byte_pulse(AW'(i), d, 4);
            model[i] = model[i] & d;
        end
        read_all("R8 AND program");

        // R6 page program of every page, lanes filled out of order
        for (int p = 0; p < NB / 4; p++) begin
            for (int e = 3; e >= 0; e--) latch_byte(AW'(p * 4 + e), pat(p * 4 + e, 3));
            page_pulse(AW'(p * 4 + 2));
            for (int e = 0; e < 4; e++)
                model[p * 4 + e] = model[p * 4 + e] & pat(p * 4 + e, 3);
        end
        read_all("R6 page program");

        // R6 buffer cleared after commit: a bare page pulse changes nothing
        latch_byte(AW'(1), 8'h00);
        page_pulse(AW'(0));
        model[1] = 8'h00;
        page_pulse(AW'(0));
        page_pulse(AW'(4));
        read_all("R6 buffer cleared");

        // R1 out of programming mode: no drive, no write
        sel_rst_n = 1'b1;
        pins(1'b0, 1'b0, 1'b1);
        addr = AW'(9);
        step();
        chk(data_oe === 1'b0, "R1 reset pin high no drive", int'(data_oe), 0);
        byte_pulse(AW'(9), 8'h00, 1);
        sel_rst_n = 1'b0;
        vpp_ok = 1'b0;
        pins(1'b0, 1'b0, 1'b1);
        step();
        chk(data_oe === 1'b0, "R1 no supply no drive", int'(data_oe), 0);
        byte_pulse(AW'(10), 8'h00, 1);
        vpp_ok = 1'b1;
        read_chk(AW'(9), "R1 cell untouched");
        read_chk(AW'(10), "R1 cell untouched");

        // R3 output disable
        pins(1'b0, 1'b1, 1'b1);
        step();
        chk(data_oe === 1'b0, "R3 output disable", int'(data_oe), 0);

        // R2 standby both encodings
        pins(1'b1, 1'b1, 1'b1);
        step();
        chk(data_oe === 1'b0, "R2 standby HHH", int'(data_oe), 0);
        pins(1'b1, 1'b0, 1'b0);
        addr = AW'(20);
        data_in = 8'h00;
        step();
        step();
        chk(data_oe === 1'b0, "R2 standby HLL", int'(data_oe), 0);
        read_chk(AW'(20), "R2 no write in standby");

        // R9 inhibit
        pins(1'b0, 1'b0, 1'b1);
        addr = AW'(21);
        step();
        pgm_n = 1'b0;
        data_in = 8'h00;
        step();
        step();
        chk(data_oe === 1'b0, "R9 inhibit no drive", int'(data_oe), 0);
        read_chk(AW'(21), "R9 no write in inhibit");

        // R10 aliasing through high address bits
        read_chk(AW'(17'h1_0000 | 17'd33), "R10 alias read");
        byte_pulse(AW'(17'h1_F000 | 17'd34), 8'h0F, 1);
        model[34] = model[34] & 8'h0F;
        read_chk(AW'(34), "R10 alias write");
        read_chk(AW'(17'h0_4000 | 17'd34), "R10 alias read back");

        pins(1'b1, 1'b1, 1'b1);
        step();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule